// File: doc/BRIEF.md
# Programmable Chip-Select Wait-State Controller

This block sits between a processor bus and up to eight external memory regions. Each incoming bus request carries a 32-bit address and a read/write flag. The controller compares the address against every programmed bank, picks the winning bank, and drives that bank's chip-select. It counts off the bank's programmed wait states and then returns a one-cycle transfer acknowledge. A write aimed at a write-protected bank is refused with a one-cycle error, and no chip-select is driven for it.

Each bank holds a base address, a block size, a port-width code, a wait count, a write-protect flag and a valid bit. All of these are written through a simple one-word-per-bank configuration port. Bank 0 serves as the boot region. It is live as soon as reset ends, covers the whole address space, uses the slowest timing, and takes its port width from a strap input.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After reset, bus_cs, bus_ack and bus_err are 0. Only bank 0 is valid. It matches every address, has 30 wait states, is not write-protected, and its port-width code equals boot_width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
- R2: A bank matches when its valid bit is set and address bits [31:15] equal cfg_base on every bit position where the bank's mask is 1. Bit i of bus_cs belongs to bank i, and at most one bit is high at any time.
- R3: When several valid banks match, the lowest-numbered bank is selected.
- R4: A bus_req is sampled on a rising edge while the block is idle. For a bank with N wait states, bus_cs rises after that edge, bus_ack is high for exactly one cycle N+1 cycles later, and bus_cs falls after the acknowledge cycle.
- R5: A cfg_waits value above 30 is stored as 30.
- R6: Size code c gives a block of 32 KB << c, with the mask clearing the low c bits of the 17-bit tag. Codes above 13 are stored as 13, which gives 256 MB.
- R7: A write to a matching write-protected bank raises bus_err for exactly one cycle after the sampling edge, with no chip-select and no acknowledge. A read of the same bank completes normally.
- R8: A request that matches no valid bank gives no chip-select, no acknowledge and no error.
- R9: While bus_cs is active, bus_width carries the selected bank's 2-bit port-width code, latched when the access starts. Otherwise it is 0.
- R10: A bus_req that arrives while an access or error is in progress is ignored. A configuration write takes effect for the following request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_width | input | 2 | Strap: port width of boot bank 0 |
| cfg_wr | input | 1 | Write one bank's configuration |
| cfg_sel | input | 3 | Bank number written |
| cfg_base | input | 17 | Base address bits [31:15] |
| cfg_size | input | 4 | Block size code |
| cfg_width | input | 2 | Port-width code |
| cfg_waits | input | 5 | Wait-state count |
| cfg_wprot | input | 1 | Write-protect flag |
| cfg_valid | input | 1 | Bank enable |
| bus_req | input | 1 | Access request, one cycle |
| bus_addr | input | 32 | Access address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cs | output | 8 | Chip-select per bank, active high |
| bus_ack | output | 1 | Transfer acknowledge pulse |
| bus_err | output | 1 | Protection error pulse |
| bus_width | output | 2 | Port-width code of the active bank |

## Verification
Counting from the edge that samples a request, bus_cs and bus_width are due one cycle later. bus_err is also due one cycle later and lasts one cycle. bus_ack is due N+1 cycles after bus_cs rises, and bus_cs clears one cycle after that. The reference model advances on the same edges as the design, and every output is compared at the falling edge once the registers have settled. Directed accesses also count falling edges from the request until bus_ack or bus_err appears, and compare that count with N+2 or 1.

// File: rtl/cswc_pkg.sv
package cswc_pkg;
    localparam int ADDR_W        = 32;
    localparam int MIN_BLK_LOG2  = 15;
    localparam int TAG_W         = ADDR_W - MIN_BLK_LOG2;
    localparam int MAX_SIZE_CODE = 13;
    localparam int SIZE_W        = 4;
    localparam int WAIT_MAX      = 30;
    localparam int WAIT_W        = $clog2(WAIT_MAX + 1);
    localparam int PW_W          = 2;

    typedef struct packed {
        logic              valid;
        logic              wprot;
        logic [PW_W-1:0]   pwidth;
        logic [WAIT_W-1:0] waits;
        logic [TAG_W-1:0]  base;
        logic [TAG_W-1:0]  mask;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_ERR  = 2'd3
    } acc_state_t;
endpackage

// File: rtl/cswc_bank_regs.sv
module cswc_bank_regs
    import cswc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int SEL_W     = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW_W-1:0]   boot_width,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [TAG_W-1:0]  cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [PW_W-1:0]   cfg_width,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic              cfg_wprot,
    input  logic              cfg_valid,
    output bank_cfg_t         banks [NUM_BANKS]
);
    bank_cfg_t regs_d [NUM_BANKS];
    bank_cfg_t regs_q [NUM_BANKS];
    bank_cfg_t new_entry;
    logic [SIZE_W-1:0] size_eff;
    logic [WAIT_W-1:0] waits_eff;

    always_comb begin
        size_eff  = (cfg_size > SIZE_W'(MAX_SIZE_CODE)) ? SIZE_W'(MAX_SIZE_CODE) : cfg_size;
        waits_eff = (cfg_waits > WAIT_W'(WAIT_MAX)) ? WAIT_W'(WAIT_MAX) : cfg_waits;
        new_entry.valid  = cfg_valid;
        new_entry.wprot  = cfg_wprot;
        new_entry.pwidth = cfg_width;
        new_entry.waits  = waits_eff;
        new_entry.base   = cfg_base;
        new_entry.mask   = {TAG_W{1'b1}} << size_eff;
        for (int i = 0; i < NUM_BANKS; i++) begin
            regs_d[i] = regs_q[i];
            if (cfg_wr && (cfg_sel == SEL_W'(i))) begin
                regs_d[i] = new_entry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NUM_BANKS; i++) begin
                regs_q[i] <= '0;
            end
            regs_q[0].valid  <= 1'b1;
            regs_q[0].wprot  <= 1'b0;
            regs_q[0].pwidth <= boot_width;
            regs_q[0].waits  <= WAIT_W'(WAIT_MAX);
            regs_q[0].base   <= '0;
            regs_q[0].mask   <= '0;
        end else begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_out
        assign banks[g] = regs_q[g];

        // R5: stored wait counts never exceed the limit
        a_r5_wait_limit: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q[g].waits <= WAIT_W'(WAIT_MAX));
    end
endmodule

// File: rtl/cswc_decode.sv
module cswc_decode
    import cswc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int SEL_W     = $clog2(NUM_BANKS)
) (
    input  bank_cfg_t          banks [NUM_BANKS],
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [SEL_W-1:0]   idx
);
    logic [NUM_BANKS-1:0] match;
    logic [TAG_W-1:0]     tag;

    assign tag = addr[ADDR_W-1:MIN_BLK_LOG2];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
        assign match[g] = banks[g].valid &&
                          (((tag ^ banks[g].base) & banks[g].mask) == '0);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/cswc_access_fsm.sv
module cswc_access_fsm
    import cswc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int SEL_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 write,
    input  logic                 hit,
    input  logic [SEL_W-1:0]     idx,
    input  bank_cfg_t            sel_cfg,
    output logic [NUM_BANKS-1:0] cs,
    output logic                 ack,
    output logic                 err,
    output logic [PW_W-1:0]      width
);
    typedef struct packed {
        acc_state_t        st;
        logic [WAIT_W-1:0] cnt;
        logic [SEL_W-1:0]  bank;
        logic [PW_W-1:0]   pw;
    } acc_t;

    acc_t acc_d, acc_q;
    logic busy;

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q.st)
            ST_IDLE: begin
                if (req && hit) begin
                    if (write && sel_cfg.wprot) begin
                        acc_d.st = ST_ERR;
                    end else begin
                        acc_d.st   = ST_WAIT;
                        acc_d.cnt  = sel_cfg.waits;
                        acc_d.bank = idx;
                        acc_d.pw   = sel_cfg.pwidth;
                    end
                end
            end
            ST_WAIT: begin
                if (acc_q.cnt == '0) begin
                    acc_d.st = ST_ACK;
                end else begin
                    acc_d.cnt = acc_q.cnt - 1'b1;
                end
            end
            ST_ACK:  acc_d.st = ST_IDLE;
            ST_ERR:  acc_d.st = ST_IDLE;
            default: acc_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '{st: ST_IDLE, cnt: '0, bank: '0, pw: '0};
        end else begin
            acc_q <= acc_d;
        end
    end

    assign busy  = (acc_q.st == ST_WAIT) || (acc_q.st == ST_ACK);
    assign cs    = busy ? (NUM_BANKS'(1) << acc_q.bank) : '0;
    assign ack   = (acc_q.st == ST_ACK);
    assign err   = (acc_q.st == ST_ERR);
    assign width = busy ? acc_q.pw : '0;

    // R2: never more than one chip-select
    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));
    // R4: acknowledge is a single-cycle pulse, then the select drops
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && cs == '0));
    // R4: acknowledge only accompanies an active select
    a_r4_ack_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs != '0));
    // R7: error is a single-cycle pulse with no select and no acknowledge
    a_r7_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs == '0 && !ack));
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    // R10: the selected bank holds steady until the acknowledge
    a_r10_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs != '0 && !ack) |=> (cs == $past(cs)));
endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
    import cswc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int SEL_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           boot_width,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [16:0]          cfg_base,
    input  logic [3:0]           cfg_size,
    input  logic [1:0]           cfg_width,
    input  logic [4:0]           cfg_waits,
    input  logic                 cfg_wprot,
    input  logic                 cfg_valid,
    input  logic                 bus_req,
    input  logic [31:0]          bus_addr,
    input  logic                 bus_write,
    output logic [NUM_BANKS-1:0] bus_cs,
    output logic                 bus_ack,
    output logic                 bus_err,
    output logic [1:0]           bus_width
);
    bank_cfg_t        banks [NUM_BANKS];
    logic             hit;
    logic [SEL_W-1:0] idx;
    bank_cfg_t        sel_cfg;

    cswc_bank_regs #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_width (boot_width),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_base   (cfg_base),
        .cfg_size   (cfg_size),
        .cfg_width  (cfg_width),
        .cfg_waits  (cfg_waits),
        .cfg_wprot  (cfg_wprot),
        .cfg_valid  (cfg_valid),
        .banks      (banks)
    );

    cswc_decode #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_dec (
        .banks (banks),
        .addr  (bus_addr),
        .hit   (hit),
        .idx   (idx)
    );

    assign sel_cfg = banks[idx];

    cswc_access_fsm #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .write   (bus_write),
        .hit     (hit),
        .idx     (idx),
        .sel_cfg (sel_cfg),
        .cs      (bus_cs),
        .ack     (bus_ack),
        .err     (bus_err),
        .width   (bus_width)
    );
endmodule

// File: tb/cs_wait_ctrl_test.sv
module cs_wait_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_width = 2'd1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [16:0] cfg_base = '0;
    logic [3:0]  cfg_size = '0;
    logic [1:0]  cfg_width = '0;
    logic [4:0]  cfg_waits = '0;
    logic        cfg_wprot = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_cs;
    logic        bus_ack, bus_err;
    logic [1:0]  bus_width;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    cs_wait_ctrl uut (.*);

    // behavioural reference model
    int          m_valid [8];
    int          m_wp    [8];
    int          m_width [8];
    int          m_wait  [8];
    logic [31:0] m_base  [8];
    logic [31:0] m_mask  [8];
    int m_bank = -1;
    int m_left = 0;
    int m_wb = 0;
    bit m_ack = 0;
    bit m_err = 0;

    function automatic int find_bank(logic [31:0] a);
        for (int i = 0; i < 8; i++)
            if (m_valid[i] != 0 && ((a ^ m_base[i]) & m_mask[i]) == 32'd0) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_valid[i] = 0; m_wp[i] = 0; m_width[i] = 0; m_wait[i] = 0;
                m_base[i] = 0; m_mask[i] = 0;
            end
            m_valid[0] = 1; m_width[0] = boot_width; m_wait[0] = 30;
            m_bank = -1; m_ack = 0; m_err = 0; m_left = 0; m_wb = 0;
        end else begin
            bit idle;
            idle = (m_bank < 0) && !m_err;
            if (m_ack) begin
                m_ack = 0; m_bank = -1;
            end else if (m_bank >= 0) begin
                if (m_left == 0) m_ack = 1; else m_left--;
            end else if (m_err) begin
                m_err = 0;
            end
            if (idle && bus_req) begin
                int b;
                b = find_bank(bus_addr);
                if (b >= 0) begin
                    if (bus_write && m_wp[b] != 0) m_err = 1;
                    else begin m_bank = b; m_left = m_wait[b]; m_wb = m_width[b]; end
                end
            end
            if (cfg_wr) begin
                int s;
                int c;
                s = cfg_sel;
                c = (cfg_size > 13) ? 13 : cfg_size;
                m_valid[s] = cfg_valid;
                m_wp[s]    = cfg_wprot;
                m_width[s] = cfg_width;
                m_wait[s]  = (cfg_waits > 30) ? 30 : cfg_waits;
                m_base[s]  = {cfg_base, 15'd0};
                m_mask[s]  = 32'hFFFF_FFFF << (15 + c);
            end
        end
    end

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] ecs;
            ecs = (m_bank >= 0) ? (8'd1 << m_bank) : 8'd0;
            check(bus_cs == ecs, phase, "bus_cs", bus_cs, ecs);
            check(bus_ack == m_ack, phase, "bus_ack", bus_ack, m_ack);
            check(bus_err == m_err, phase, "bus_err", bus_err, m_err);
            check(bus_width == ((m_bank >= 0) ? m_wb : 0), "R9", "bus_width",
                  bus_width, (m_bank >= 0) ? m_wb : 0);
        end
    end

    task automatic cfg(int sel, logic [31:0] base, int size, int width, int waits, bit wp, bit v);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = 3'(sel); cfg_base = base[31:15]; cfg_size = 4'(size);
        cfg_width = 2'(width); cfg_waits = 5'(waits); cfg_wprot = wp; cfg_valid = v;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    // kind: 0 miss, 1 acknowledged access, 2 protection error
    task automatic access(logic [31:0] a, bit wr, int kind, int bank, int waits, string tag);
        int n;
        bit seen_cs;
        phase = tag;
        @(negedge clk);
        bus_req = 1; bus_addr = a; bus_write = wr;
        n = 0; seen_cs = 0;
        while (n < 40) begin
            @(negedge clk);
            bus_req = 0;
            n++;
            if (bus_cs == (8'd1 << bank)) seen_cs = 1;
            if (bus_ack || bus_err || (kind == 0 && n == 4)) break;
        end
        if (kind == 1) begin
            check(bus_ack && seen_cs, tag, "ack from bank", bus_cs, 8'd1 << bank);
            check(n == waits + 2, tag, "ack latency", n, waits + 2);
        end else if (kind == 2) begin
            check(bus_err && n == 1, tag, "err latency", n, 1);
        end else begin
            check(!bus_ack && !bus_err && bus_cs == 0, tag, "miss quiet", bus_cs, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(bus_cs == 0 && !bus_ack && !bus_err, "R1", "reset outputs", bus_cs, 0);
        // R1: boot bank covers everything, 30 waits, strap width 16-bit
        access(32'hC123_4560, 0, 1, 0, 30, "R1");
        access(32'h0000_0000, 1, 1, 0, 30, "R1");
        // R2: reprogram bank 0 to 256 MB at 0, 0 waits, 8-bit
        cfg(0, 32'h0000_0000, 13, 0, 0, 0, 1);
        access(32'h0FFF_FFFC, 0, 1, 0, 0, "R2");
        access(32'h2000_0000, 0, 0, 0, 0, "R8");
        // R3: bank 2 inside bank 0 loses to bank 0
        cfg(2, 32'h0800_0000, 5, 2, 3, 0, 1);
        access(32'h0800_0010, 0, 1, 0, 0, "R3");
        // R5: waits 31 clamps to 30; R7 protected
        cfg(3, 32'h2000_0000, 0, 1, 31, 1, 1);
        access(32'h2000_7FFC, 0, 1, 3, 30, "R5");
        access(32'h2000_0010, 1, 2, 3, 0, "R7");
        // R6: 32 KB boundary
        access(32'h2000_8000, 0, 0, 0, 0, "R6");
        // R6: code 15 clamps to 256 MB
        cfg(5, 32'h3000_0000, 15, 2, 2, 0, 1);
        access(32'h3FFF_FFFC, 1, 1, 5, 2, "R6");
        access(32'h4000_0000, 0, 0, 0, 0, "R6");
        // R3: overlapping banks 6 and 7, lower wins
        cfg(7, 32'h5000_0000, 3, 3, 1, 0, 1);
        cfg(6, 32'h5000_0000, 3, 1, 4, 0, 1);
        access(32'h5000_0100, 0, 1, 6, 4, "R3");
        // R2: invalid bank no longer matches
        cfg(6, 32'h5000_0000, 3, 1, 4, 0, 0);
        access(32'h5000_0100, 0, 1, 7, 1, "R2");
        cfg(5, 32'h3000_0000, 13, 2, 2, 0, 0);
        access(32'h3000_0000, 0, 0, 0, 0, "R2");
        // R10: second request during a wait is ignored
        phase = "R10";
        @(negedge clk);
        bus_req = 1; bus_addr = 32'h2000_0000; bus_write = 0;
        @(negedge clk);
        bus_addr = 32'h5000_0000;
        @(negedge clk);
        bus_req = 0;
        check(bus_cs == 8'h08, "R10", "cs held on busy request", bus_cs, 8'h08);
        repeat (35) @(negedge clk);
        check(bus_cs == 0, "R10", "no second access", bus_cs, 0);
        // R10: config write takes effect for the next request
        cfg(3, 32'h2000_0000, 0, 1, 2, 0, 1);
        access(32'h2000_0000, 1, 1, 3, 2, "R10");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule